// File: doc/BRIEF.md
# Host Platform Power-State Sequencer

This block is a clocked state machine that carries a host platform between four steady power states: hard-off, soft-off, suspend and on. Six transition states sit between them, and each one drives the platform's rail enables and handshake lines in a fixed order with fixed delays. The block watches a six-bit power-good vector and two active-low sleep requests from the platform controller. Where a sequence has to wait for rails, the wait is bounded. A wait that expires produces a one-cycle timeout status that names the wanted and received power-good bits, and the sequence then carries on.

All delays are written in milliseconds and converted to clock cycles through the `TICKS_PER_MS` parameter. The short power-ok-to-core-disable gap is the exception: it is given directly in cycles.

A wake pulse takes the machine out of hard-off. If soft-off sees no request to power up for the idle period, the machine drops back to hard-off. A ten-bit one-hot code on the output always shows the current state.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is high, every enable output, `deep_pwr_ok` and `host_pwr_ok` are 0. `rsm_rst_n`, `tscr_rst_n` and `cpu_init_n` are 0 (asserted). `state_code` is bit 4 (hard-off to soft-off). The first clock edge after reset raises `en_5v_alw`.
- R2: In hard-off to soft-off, `en_5v_alw` rises first. Once `pg[0]` (always-on good) is seen, 10 ms later `deep_pwr_ok` rises and `rsm_rst_n` is released together. 5 ms after that the state becomes soft-off (`state_code` bit 1). With `pg[0]` already high, the gap from `en_5v_alw` rising to `deep_pwr_ok` rising is 10 ms plus one cycle.
- R3: In soft-off, `slp_s5_n`=1 leads through the soft-off to suspend state (bit 5) to suspend (bit 2) in two cycles. That transition raises `en_ddr`, `en_tpad` and `tscr_rst_n`.
- R4: If soft-off does not see `slp_s5_n`=1 within 10 s of entry, the machine passes through soft-off to hard-off (bit 9) to hard-off (bit 0). On the way it drops `deep_pwr_ok`, asserts `rsm_rst_n` and drops `en_5v_alw`, and any pending wake is cleared.
- R5: A one-cycle `wake_req` pulse is latched only in hard-off (bit 0) or in soft-off to hard-off (bit 9). A latched wake moves hard-off to bit 4 on the next edge. A pulse in any other state has no effect.
- R6: In suspend, `slp_s3_n`=1 enters suspend to on (bit 6). Otherwise `slp_s5_n`=0 enters suspend to soft-off (bit 8), which drops `en_ddr`, `en_tpad` and `tscr_rst_n` and enters soft-off on the next edge.
- R7: In suspend to on, `cpu_init_n`, `en_sw_rails` and all three `radio_en` bits rise first. `en_core` rises once `pg[5:1]` are all good. 99 ms later `host_pwr_ok` rises and the state becomes on (bit 3).
- R8: In on, `slp_s3_n`=0 enters on to suspend (bit 7). `host_pwr_ok` falls first. `GAP_CYC` cycles later, `en_core`, `cpu_init_n`, `radio_en` and `en_sw_rails` fall together and the state becomes suspend.
- R9: A power-good wait gives up 1 s after it starts. At that edge `pg_tmo` pulses for one cycle, `pg_tmo_want` shows the wanted mask and `pg_tmo_got` shows the wanted bits that were high. The wanted mask is 6'b000001 in hard-off to soft-off and 6'b111110 in suspend to on. The sequence then continues as if the rails were good.
- R10: `sus_ack_n` follows `sus_warn_n` combinationally in every state, including reset.
- R11: `state_code` is one-hot at all times, with bit index hard-off 0, soft-off 1, suspend 2, on 3, hard-off to soft-off 4, soft-off to suspend 5, suspend to on 6, on to suspend 7, suspend to soft-off 8, soft-off to hard-off 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Request to leave hard-off (pulse) |
| pg | input | 6 | Power-good: bit 0 always-on supply, bits 5:1 non-core rails |
| slp_s3_n | input | 1 | Suspend request from the platform controller, active low |
| slp_s5_n | input | 1 | Soft-off request from the platform controller, active low |
| sus_warn_n | input | 1 | Suspend-well warning, active low |
| en_5v_alw | output | 1 | Always-on 5 V supply enable |
| deep_pwr_ok | output | 1 | Deep-well power-ok to the platform controller |
| rsm_rst_n | output | 1 | Resume-well reset, active low |
| en_ddr | output | 1 | DRAM supply enable |
| en_tpad | output | 1 | Touchpad supply enable |
| tscr_rst_n | output | 1 | Touchscreen reset, active low |
| cpu_init_n | output | 1 | CPU-init request line, active low |
| en_sw_rails | output | 1 | Switched-rail enable |
| radio_en | output | 3 | Wireless enables |
| en_core | output | 1 | Core regulator enable |
| host_pwr_ok | output | 1 | Power-ok to the platform controller |
| sus_ack_n | output | 1 | Suspend-well acknowledge, active low |
| state_code | output | 10 | One-hot state code |
| pg_tmo | output | 1 | One-cycle power-good timeout status |
| pg_tmo_want | output | 6 | Wanted mask of the last timed-out wait |
| pg_tmo_got | output | 6 | Wanted bits seen high at the last timeout |

## Verification
The assertions assume that the sleep requests move slowly next to the sequencer. They assume that `slp_s3_n` is never high while `slp_s5_n` is low, and that `wake_req` is a short pulse. The stimulus changes one request at a time, only on a falling clock edge, and only after the machine has settled in a steady state. It drops rails only to provoke the bounded waits, and it raises them again before the next sequence starts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int NUM_STATES = 10;
    localparam int PG_W       = 6;

    localparam logic [PG_W-1:0] WANT_ALW     = 6'b000001;
    localparam logic [PG_W-1:0] WANT_NONCORE = 6'b111110;

    typedef enum logic [3:0] {
        ST_HOFF      = 4'd0,
        ST_SOFF      = 4'd1,
        ST_SUSP      = 4'd2,
        ST_ON        = 4'd3,
        ST_HOFF_SOFF = 4'd4,
        ST_SOFF_SUSP = 4'd5,
        ST_SUSP_ON   = 4'd6,
        ST_ON_SUSP   = 4'd7,
        ST_SUSP_SOFF = 4'd8,
        ST_SOFF_HOFF = 4'd9
    } pstate_e;

    typedef struct packed {
        logic       en_5v;
        logic       deep_ok;
        logic       rsm_rel;
        logic       en_ddr;
        logic       en_tpad;
        logic       tscr_rel;
        logic       init_rel;
        logic       en_sw;
        logic [2:0] radio;
        logic       en_core;
        logic       pwr_ok;
    } rail_out_t;

    function automatic logic [NUM_STATES-1:0] state_onehot(pstate_e s);
        logic [NUM_STATES-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pwr_cycle_timer.sv
module pwr_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwr_pg_match.sv
module pwr_pg_match #(
    parameter int W = 6
) (
    input  logic [W-1:0] pg,
    input  logic [W-1:0] want,
    output logic [W-1:0] got,
    output logic         met
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign got[i] = pg[i] & want[i];
    end
    assign met = (got == want);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS   = 50000,
    parameter int unsigned GAP_CYC        = 2,
    parameter int unsigned RAIL_SETTLE_MS = 10,
    parameter int unsigned CLK_STABLE_MS  = 5,
    parameter int unsigned CORE_SETTLE_MS = 99,
    parameter int unsigned PG_TIMEOUT_MS  = 1000,
    parameter int unsigned SOFF_IDLE_MS   = 10000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wake_req,
    input  logic [PG_W-1:0]       pg,
    input  logic                  slp_s3_n,
    input  logic                  slp_s5_n,
    input  logic                  sus_warn_n,
    output logic                  en_5v_alw,
    output logic                  deep_pwr_ok,
    output logic                  rsm_rst_n,
    output logic                  en_ddr,
    output logic                  en_tpad,
    output logic                  tscr_rst_n,
    output logic                  cpu_init_n,
    output logic                  en_sw_rails,
    output logic [2:0]            radio_en,
    output logic                  en_core,
    output logic                  host_pwr_ok,
    output logic                  sus_ack_n,
    output logic [NUM_STATES-1:0] state_code,
    output logic                  pg_tmo,
    output logic [PG_W-1:0]       pg_tmo_want,
    output logic [PG_W-1:0]       pg_tmo_got
);
    localparam int unsigned C_SETTLE = RAIL_SETTLE_MS * TICKS_PER_MS;
    localparam int unsigned C_STABLE = CLK_STABLE_MS * TICKS_PER_MS;
    localparam int unsigned C_CORE   = CORE_SETTLE_MS * TICKS_PER_MS;
    localparam int unsigned C_TMO    = PG_TIMEOUT_MS * TICKS_PER_MS;
    localparam int unsigned C_IDLE   = SOFF_IDLE_MS * TICKS_PER_MS;
    localparam int          CNT_W    = $clog2(C_IDLE + 1);

    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(C_SETTLE - 1);
    localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(C_STABLE - 1);
    localparam logic [CNT_W-1:0] LD_CORE   = CNT_W'(C_CORE - 1);
    localparam logic [CNT_W-1:0] LD_TMO    = CNT_W'(C_TMO - 1);
    localparam logic [CNT_W-1:0] LD_IDLE   = CNT_W'(C_IDLE - 1);
    localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(GAP_CYC - 1);

    pstate_e          st, st_n;
    logic [1:0]       phase, phase_n;
    rail_out_t        ro, ro_n;
    logic             wake_pend, wake_clr;
    logic             tmo_n;
    logic [PG_W-1:0]  tw_n, tg_n;
    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    logic [PG_W-1:0]  want, got;
    logic             met;

    pwr_cycle_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    assign want = (st == ST_HOFF_SOFF) ? WANT_ALW : WANT_NONCORE;

    pwr_pg_match #(.W(PG_W)) u_match (
        .pg   (pg),
        .want (want),
        .got  (got),
        .met  (met)
    );

    always_comb begin
        st_n     = st;
        phase_n  = phase;
        ro_n     = ro;
        t_load   = 1'b0;
        t_val    = '0;
        tmo_n    = 1'b0;
        tw_n     = pg_tmo_want;
        tg_n     = pg_tmo_got;
        wake_clr = 1'b0;

        case (st)
            ST_HOFF: begin
                if (wake_pend) begin
                    st_n     = ST_HOFF_SOFF;
                    phase_n  = 2'd0;
                    wake_clr = 1'b1;
                end
            end
            ST_HOFF_SOFF: begin
                case (phase)
                    2'd0: begin
                        ro_n.en_5v = 1'b1;
                        t_load     = 1'b1;
                        t_val      = LD_TMO;
                        phase_n    = 2'd1;
                    end
                    2'd1: begin
                        if (met || t_done) begin
                            if (!met) begin
                                tmo_n = 1'b1;
                                tw_n  = want;
                                tg_n  = got;
                            end
                            t_load  = 1'b1;
                            t_val   = LD_SETTLE;
                            phase_n = 2'd2;
                        end
                    end
                    2'd2: begin
                        if (t_done) begin
                            ro_n.deep_ok = 1'b1;
                            ro_n.rsm_rel = 1'b1;
                            t_load       = 1'b1;
                            t_val        = LD_STABLE;
                            phase_n      = 2'd3;
                        end
                    end
                    default: begin
                        if (t_done) begin
                            st_n    = ST_SOFF;
                            phase_n = 2'd0;
                            t_load  = 1'b1;
                            t_val   = LD_IDLE;
                        end
                    end
                endcase
            end
            ST_SOFF: begin
                if (slp_s5_n) begin
                    st_n = ST_SOFF_SUSP;
                end else if (t_done) begin
                    st_n     = ST_SOFF_HOFF;
                    wake_clr = 1'b1;
                end
            end
            ST_SOFF_SUSP: begin
                ro_n.en_ddr   = 1'b1;
                ro_n.en_tpad  = 1'b1;
                ro_n.tscr_rel = 1'b1;
                st_n          = ST_SUSP;
            end
            ST_SUSP: begin
                if (slp_s3_n) begin
                    st_n    = ST_SUSP_ON;
                    phase_n = 2'd0;
                end else if (!slp_s5_n) begin
                    st_n = ST_SUSP_SOFF;
                end
            end
            ST_SUSP_ON: begin
                case (phase)
                    2'd0: begin
                        ro_n.init_rel = 1'b1;
                        ro_n.en_sw    = 1'b1;
                        ro_n.radio    = '1;
                        t_load        = 1'b1;
                        t_val         = LD_TMO;
                        phase_n       = 2'd1;
                    end
                    2'd1: begin
                        if (met || t_done) begin
                            if (!met) begin
                                tmo_n = 1'b1;
                                tw_n  = want;
                                tg_n  = got;
                            end
                            ro_n.en_core = 1'b1;
                            t_load       = 1'b1;
                            t_val        = LD_CORE;
                            phase_n      = 2'd2;
                        end
                    end
                    default: begin
                        if (t_done) begin
                            ro_n.pwr_ok = 1'b1;
                            st_n        = ST_ON;
                            phase_n     = 2'd0;
                        end
                    end
                endcase
            end
            ST_ON: begin
                if (!slp_s3_n) begin
                    st_n    = ST_ON_SUSP;
                    phase_n = 2'd0;
                end
            end
            ST_ON_SUSP: begin
                if (phase == 2'd0) begin
                    ro_n.pwr_ok = 1'b0;
                    t_load      = 1'b1;
                    t_val       = LD_GAP;
                    phase_n     = 2'd1;
                end else if (t_done) begin
                    ro_n.en_core  = 1'b0;
                    ro_n.init_rel = 1'b0;
                    ro_n.radio    = '0;
                    ro_n.en_sw    = 1'b0;
                    st_n          = ST_SUSP;
                    phase_n       = 2'd0;
                end
            end
            ST_SUSP_SOFF: begin
                ro_n.en_tpad  = 1'b0;
                ro_n.tscr_rel = 1'b0;
                ro_n.en_ddr   = 1'b0;
                st_n          = ST_SOFF;
                t_load        = 1'b1;
                t_val         = LD_IDLE;
            end
            ST_SOFF_HOFF: begin
                ro_n.deep_ok = 1'b0;
                ro_n.rsm_rel = 1'b0;
                ro_n.en_5v   = 1'b0;
                st_n         = ST_HOFF;
            end
            default: begin
                st_n    = ST_HOFF_SOFF;
                phase_n = 2'd0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_HOFF_SOFF;
            phase       <= 2'd0;
            ro          <= '0;
            pg_tmo      <= 1'b0;
            pg_tmo_want <= '0;
            pg_tmo_got  <= '0;
        end else begin
            st          <= st_n;
            phase       <= phase_n;
            ro          <= ro_n;
            pg_tmo      <= tmo_n;
            pg_tmo_want <= tw_n;
            pg_tmo_got  <= tg_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            wake_pend <= 1'b0;
        else if (wake_clr)
            wake_pend <= 1'b0;
        else if (wake_req && (st == ST_HOFF || st == ST_SOFF_HOFF))
            wake_pend <= 1'b1;
    end

    assign en_5v_alw   = ro.en_5v;
    assign deep_pwr_ok = ro.deep_ok;
    assign rsm_rst_n   = ro.rsm_rel;
    assign en_ddr      = ro.en_ddr;
    assign en_tpad     = ro.en_tpad;
    assign tscr_rst_n  = ro.tscr_rel;
    assign cpu_init_n  = ro.init_rel;
    assign en_sw_rails = ro.en_sw;
    assign radio_en    = ro.radio;
    assign en_core     = ro.en_core;
    assign host_pwr_ok = ro.pwr_ok;
    assign sus_ack_n   = sus_warn_n;
    assign state_code  = state_onehot(st);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
    import pwr_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  en_5v_alw,
    input logic                  deep_pwr_ok,
    input logic                  rsm_rst_n,
    input logic                  en_ddr,
    input logic                  cpu_init_n,
    input logic                  en_sw_rails,
    input logic [2:0]            radio_en,
    input logic                  en_core,
    input logic                  host_pwr_ok,
    input logic [NUM_STATES-1:0] state_code,
    input logic                  pg_tmo,
    input logic [PG_W-1:0]       pg_tmo_want,
    input logic [PG_W-1:0]       pg_tmo_got
);
    // R11
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_code) == 1);

    // R2
    deep_ok_after_5v_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(deep_pwr_ok) |-> $past(en_5v_alw) && rsm_rst_n);

    // R7
    pwr_ok_after_core_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_pwr_ok) |-> $past(en_core) && cpu_init_n && en_sw_rails);

    // R8
    core_off_after_pwr_ok_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en_core) |-> !$past(host_pwr_ok) && radio_en == 3'b000);

    // R6
    ddr_off_after_sw_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en_ddr) |-> !en_sw_rails && !en_core);

    // R9
    tmo_partial_chk: assert property (@(posedge clk) disable iff (rst)
        pg_tmo |-> ((pg_tmo_got & ~pg_tmo_want) == '0) && (pg_tmo_got != pg_tmo_want));

    // R4
    hard_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state_code[0] |-> !en_5v_alw && !deep_pwr_ok && !rsm_rst_n);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_5v_alw   (en_5v_alw),
    .deep_pwr_ok (deep_pwr_ok),
    .rsm_rst_n   (rsm_rst_n),
    .en_ddr      (en_ddr),
    .cpu_init_n  (cpu_init_n),
    .en_sw_rails (en_sw_rails),
    .radio_en    (radio_en),
    .en_core     (en_core),
    .host_pwr_ok (host_pwr_ok),
    .state_code  (state_code),
    .pg_tmo      (pg_tmo),
    .pg_tmo_want (pg_tmo_want),
    .pg_tmo_got  (pg_tmo_got)
);

// File: tb/pwr_seq_top_test.sv
`timescale 1ns/1ps
module pwr_seq_top_test;
    localparam int T    = 2;
    localparam int GAP  = 2;
    localparam int D10  = 10 * T;
    localparam int D5   = 5 * T;
    localparam int D99  = 99 * T;
    localparam int DTMO = 1000 * T;
    localparam int DIDL = 10000 * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake_req = 1'b0;
    logic [5:0] pg = 6'b000001;
    logic slp_s3_n = 1'b0;
    logic slp_s5_n = 1'b0;
    logic sus_warn_n = 1'b1;
    logic en_5v_alw, deep_pwr_ok, rsm_rst_n, en_ddr, en_tpad, tscr_rst_n;
    logic cpu_init_n, en_sw_rails, en_core, host_pwr_ok, sus_ack_n, pg_tmo;
    logic [2:0] radio_en;
    logic [9:0] state_code;
    logic [5:0] pg_tmo_want, pg_tmo_got;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_seq_top #(.TICKS_PER_MS(T), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst(rst), .wake_req(wake_req), .pg(pg),
        .slp_s3_n(slp_s3_n), .slp_s5_n(slp_s5_n), .sus_warn_n(sus_warn_n),
        .en_5v_alw(en_5v_alw), .deep_pwr_ok(deep_pwr_ok), .rsm_rst_n(rsm_rst_n),
        .en_ddr(en_ddr), .en_tpad(en_tpad), .tscr_rst_n(tscr_rst_n),
        .cpu_init_n(cpu_init_n), .en_sw_rails(en_sw_rails), .radio_en(radio_en),
        .en_core(en_core), .host_pwr_ok(host_pwr_ok), .sus_ack_n(sus_ack_n),
        .state_code(state_code), .pg_tmo(pg_tmo), .pg_tmo_want(pg_tmo_want),
        .pg_tmo_got(pg_tmo_got)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint code_of(int idx);
        return longint'(10'b1 << idx);
    endfunction

    task automatic wait_state(input int idx);
        while (!state_code[idx]) @(negedge clk);
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    initial begin
        int t0, t1, t2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({en_5v_alw, deep_pwr_ok, rsm_rst_n, en_ddr, en_tpad, tscr_rst_n,
             cpu_init_n, en_sw_rails, en_core, host_pwr_ok} == 10'b0 && radio_en == 3'b0,
            "R1 outputs in reset", {en_5v_alw, deep_pwr_ok, rsm_rst_n}, 0);
        chk(state_code == 10'b1 << 4, "R1 state code in reset", state_code, code_of(4));
        // R10 during reset
        sus_warn_n = 1'b0; #1;
        chk(sus_ack_n == 1'b0, "R10 ack low", sus_ack_n, 0);
        sus_warn_n = 1'b1; #1;
        chk(sus_ack_n == 1'b1, "R10 ack high", sus_ack_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(en_5v_alw == 1'b1, "R1 5V enable after reset", en_5v_alw, 1);
        t0 = cyc;

        // R2 timing with always-on good already high
        while (!deep_pwr_ok) @(negedge clk);
        t1 = cyc;
        chk(t1 - t0 == D10 + 1, "R2 5V to deep-ok gap", t1 - t0, D10 + 1);
        chk(rsm_rst_n == 1'b1, "R2 resume reset released", rsm_rst_n, 1);
        wait_state(1);
        t2 = cyc;
        chk(t2 - t1 == D5, "R2 deep-ok to soft-off gap", t2 - t1, D5);

        // R5 wake in soft-off is ignored; R4 idle fall-back
        repeat (5) @(negedge clk);
        pulse_wake();
        wait_state(0);
        chk(cyc - t2 == DIDL + 1, "R4 idle time to hard-off", cyc - t2, DIDL + 1);
        chk({en_5v_alw, deep_pwr_ok, rsm_rst_n} == 3'b000, "R4 rails dropped",
            {en_5v_alw, deep_pwr_ok, rsm_rst_n}, 0);
        repeat (10) @(negedge clk);
        chk(state_code == 10'b1, "R5 wake in soft-off ignored", state_code, 1);

        // R5 wake from hard-off; R9 timeout on always-on rail
        pg = 6'b000000;
        t0 = cyc;
        pulse_wake();
        while (!en_5v_alw) @(negedge clk);
        chk(cyc - t0 == 3, "R5 wake to 5V enable", cyc - t0, 3);
        t1 = cyc;
        while (!pg_tmo) @(negedge clk);
        chk(cyc - t1 == DTMO, "R9 timeout length", cyc - t1, DTMO);
        chk(pg_tmo_want == 6'b000001 && pg_tmo_got == 6'b000000, "R9 always-on status",
            {pg_tmo_want, pg_tmo_got}, 12'b000001_000000);
        t2 = cyc;
        @(negedge clk);
        chk(pg_tmo == 1'b0, "R9 single-cycle status", pg_tmo, 0);
        pg = 6'b000001;
        while (!deep_pwr_ok) @(negedge clk);
        chk(cyc - t2 == D10, "R9 sequence continues", cyc - t2, D10);
        wait_state(1);

        // R3 soft-off to suspend
        slp_s5_n = 1'b1;
        @(negedge clk);
        chk(state_code == 10'b1 << 5, "R3 transition code", state_code, code_of(5));
        @(negedge clk);
        chk(state_code == 10'b1 << 2 && en_ddr && en_tpad && tscr_rst_n,
            "R3 suspend rails", {en_ddr, en_tpad, tscr_rst_n}, 7);

        // R7 suspend to on, rails good
        pg = 6'b111111;
        slp_s3_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(state_code[6] && cpu_init_n && en_sw_rails && radio_en == 3'b111 && !en_core,
            "R7 first step order", {cpu_init_n, en_sw_rails, radio_en, en_core}, 6'b111110);
        t0 = cyc;
        @(negedge clk);
        chk(en_core == 1'b1, "R7 core after rails good", en_core, 1);
        while (!host_pwr_ok) @(negedge clk);
        chk(cyc - t0 == D99 + 1, "R7 core to power-ok gap", cyc - t0, D99 + 1);
        chk(state_code == 10'b1 << 3, "R7 on state", state_code, code_of(3));
        // R10 in on state
        sus_warn_n = 1'b0; #1;
        chk(sus_ack_n == 1'b0, "R10 ack in on", sus_ack_n, 0);
        sus_warn_n = 1'b1;

        // R8 on to suspend
        slp_s3_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!host_pwr_ok && en_core && cpu_init_n, "R8 power-ok drops first",
            {host_pwr_ok, en_core, cpu_init_n}, 3'b011);
        t0 = cyc;
        while (en_core) @(negedge clk);
        chk(cyc - t0 == GAP, "R8 gap cycles", cyc - t0, GAP);
        chk(!cpu_init_n && !en_sw_rails && radio_en == 3'b000 && state_code == 10'b100,
            "R8 rails off in suspend", {cpu_init_n, en_sw_rails, radio_en}, 0);

        // R9 timeout on non-core rails
        pg = 6'b111011;
        slp_s3_n = 1'b1;
        repeat (2) @(negedge clk);
        t0 = cyc;
        while (!pg_tmo) @(negedge clk);
        chk(cyc - t0 == DTMO, "R9 non-core timeout length", cyc - t0, DTMO);
        chk(pg_tmo_want == 6'b111110 && pg_tmo_got == 6'b111010 && en_core,
            "R9 non-core status", {pg_tmo_want, pg_tmo_got}, 12'b111110_111010);
        wait_state(3);
        slp_s3_n = 1'b0;
        wait_state(2);
        pg = 6'b111111;

        // R5 wake in suspend ignored; R6 suspend to soft-off
        pulse_wake();
        slp_s5_n = 1'b0;
        @(negedge clk);
        chk(state_code == 10'b1 << 8, "R6 transition code", state_code, code_of(8));
        @(negedge clk);
        chk(state_code == 10'b10 && !en_ddr && !en_tpad && !tscr_rst_n,
            "R6 soft-off rails", {en_ddr, en_tpad, tscr_rst_n}, 0);
        wait_state(0);
        repeat (10) @(negedge clk);
        chk(state_code == 10'b1, "R5 wake in suspend ignored", state_code, 1);

        // R5 wake latched during soft-off to hard-off
        pulse_wake();
        wait_state(1);
        wait_state(9);
        pulse_wake();
        chk(state_code == 10'b1, "R4 hard-off reached", state_code, 1);
        @(negedge clk);
        chk(state_code == 10'b1 << 4, "R5 wake in drop-back honoured", state_code, code_of(4));

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule